// File: doc/BRIEF.md
# Time-Sliced Thread Slot Scheduler

This block chooses, every clock, which hardware thread context of a hard time-sliced multithreaded processor may issue an instruction. Every context keeps its own register storage, so a change of thread needs no save or restore: the scheduler only produces a thread index and a valid flag, and the pipeline fetches from that context. Ordinary threads own fixed slots in a rotation, so the slot a thread gets never depends on what the other threads are doing.

One extra context is kept for interrupt service. The interrupt thread can be scheduled under two policies. Under the first-free policy, a pending interrupt takes any slot that its owning ordinary thread leaves unused. This loses no bandwidth, but the response time depends on how busy the threads are. Under the reserved policy, every second slot belongs to the interrupt thread. This bounds the response to one or two clocks, but the ordinary threads together get at most half of the issue bandwidth. The policy input is sampled only at a rotation boundary, so a rotation in progress is never reshaped.

Top module: `tslot_sched`

## Requirements
- R1: Under the first-free policy (policy_reserved = 0), counting clocks from the end of reset with no policy change, slot k belongs to ordinary thread k mod NUM_THREADS. That thread issues in that slot when its ready bit is high.
- R2: Ordinary threads carry issue_tid values 0 to NUM_THREADS-1. The interrupt thread carries issue_tid = NUM_THREADS. issue_tid is 0 whenever issue_valid is low.
- R3: Under the first-free policy, a pending interrupt issues in a slot whose owning thread is not ready. If the owner is ready, the owner issues and the interrupt waits. A slot with no ready owner and no pending interrupt is a bubble (issue_valid = 0).
- R4: Under the reserved policy (policy_reserved = 1), slots alternate between ordinary and reserved, starting with an ordinary slot at each rotation start. Ordinary slots walk threads 0 to NUM_THREADS-1 in order. A reserved slot issues only the interrupt thread, or else is a bubble. An ordinary slot whose thread is not ready is a bubble. Ordinary threads never issue in two consecutive clocks.
- R5: Under the reserved policy, when an interrupt request is first sampled high at the end of clock c, the interrupt thread issues in clock c+1 or c+2.
- R6: The clock in which a given ordinary thread may issue is independent of the ready bits of all other threads.
- R7: irq_ack is high exactly in the clock in which the interrupt thread issues. Each request produces one such issue. After that, the request has no effect until it has been sampled low and then high again.
- R8: A change of policy_reserved takes effect only at the next rotation start. A rotation is NUM_THREADS clocks under the first-free policy and 2*NUM_THREADS clocks under the reserved policy.
- R9: While rst is high, issue_valid and irq_ack are low. The policy is taken from policy_reserved. The first clock after reset is the ordinary slot of thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thread_ready | input | NUM_THREADS | Per-thread ready-to-issue flags |
| irq_req | input | 1 | Interrupt request level |
| policy_reserved | input | 1 | 0 = first-free policy, 1 = reserved alternate-slot policy |
| issue_valid | output | 1 | A thread issues this clock |
| issue_tid | output | $clog2(NUM_THREADS+1) | Issuing thread index; NUM_THREADS is the interrupt thread |
| irq_ack | output | 1 | Interrupt thread issues this clock |

## Verification
The bench measures interrupt latency under the reserved policy with the request arriving both before an ordinary slot and before a reserved slot. A design that lets ordinary threads use an idle reserved slot, or that serves the request late, falls outside the one-to-two clock window. It flips the policy in the middle of a rotation and expects the old slot pattern to continue until the wrap. A design that switches at once shows a bubble or an ordinary issue in the wrong clock. It holds the request high after its acknowledge and expects no second acknowledge until the request has gone low and high again. It also keeps one thread always ready while the ready bits of the other threads change at random, and expects that thread to issue only at its own fixed offset in the rotation.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  typedef enum logic {
    POL_FIRST_FREE = 1'b0,
    POL_RESERVED   = 1'b1
  } policy_e;

  // True in the last slot of a rotation.
  function automatic logic rot_last(int idx, int nthr, logic reserved, logic res_slot);
    return (idx == nthr - 1) && (!reserved || res_slot);
  endfunction

  // Ordinary pointer for the next slot.
  function automatic int rot_next(int idx, int nthr, logic reserved, logic res_slot);
    if (rot_last(idx, nthr, reserved, res_slot)) return 0;
    if (reserved && !res_slot) return idx;
    return idx + 1;
  endfunction

endpackage

// File: rtl/tslot_sequencer.sv
module tslot_sequencer
  import tslot_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int IW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          policy_i,
  output logic [IW-1:0] owner_o,
  output logic          res_slot_o,
  output logic          mode_o,
  output logic          last_o
);

  logic [IW-1:0] owner_q;
  logic          res_q;
  policy_e       mode_q;

  assign last_o     = rot_last(int'(owner_q), NUM_THREADS, mode_q == POL_RESERVED, res_q);
  assign owner_o    = owner_q;
  assign res_slot_o = res_q;
  assign mode_o     = (mode_q == POL_RESERVED);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      res_q   <= 1'b0;
      mode_q  <= policy_e'(policy_i);
    end else begin
      owner_q <= IW'(rot_next(int'(owner_q), NUM_THREADS, mode_q == POL_RESERVED, res_q));
      res_q   <= !last_o && (mode_q == POL_RESERVED) && !res_q;
      if (last_o) mode_q <= policy_e'(policy_i);
    end
  end

  // Reserved slots exist only under the reserved policy (R4)
  assert_res_slot_mode_R4: assert property (@(posedge clk) disable iff (rst)
    res_q |-> (mode_q == POL_RESERVED));

  // Owner pointer stays within the thread range (R1)
  assert_owner_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(owner_q) < NUM_THREADS);

  // The policy only moves at a rotation boundary (R8)
  assert_policy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !last_o |=> $stable(mode_q));

endmodule

// File: rtl/tslot_irq_tracker.sv
module tslot_irq_tracker (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic grant_i,
  output logic pend_o
);

  logic pend_q;
  logic armed_q;
  logic capture;

  assign capture = req_i && armed_q && !pend_q;
  assign pend_o  = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (grant_i)      pend_q <= 1'b0;
      else if (capture) pend_q <= 1'b1;
      if (!req_i)       armed_q <= 1'b1;
      else if (capture) armed_q <= 1'b0;
    end
  end

  // A grant is only given for a pending request (R7)
  assert_grant_pending_R7: assert property (@(posedge clk) disable iff (rst)
    grant_i |-> pend_q);

  // One grant per request: the pending flag clears after a grant (R7)
  assert_grant_clears_R7: assert property (@(posedge clk) disable iff (rst)
    grant_i |=> !pend_q);

endmodule

// File: rtl/tslot_issue_select.sv
module tslot_issue_select #(
  parameter int NUM_THREADS = 8,
  localparam int IW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int TW = $clog2(NUM_THREADS + 1)
) (
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [IW-1:0]          owner_i,
  input  logic                   res_slot_i,
  input  logic                   mode_i,
  input  logic                   pend_i,
  output logic                   valid_o,
  output logic [TW-1:0]          tid_o,
  output logic                   irq_grant_o,
  output logic                   ord_fire_o
);

  localparam logic [TW-1:0] IRQ_TID = TW'(NUM_THREADS);

  always_comb begin
    valid_o     = 1'b0;
    tid_o       = '0;
    irq_grant_o = 1'b0;
    ord_fire_o  = 1'b0;
    if (!rst) begin
      if (res_slot_i) begin
        irq_grant_o = pend_i;
      end else if (ready_i[owner_i]) begin
        ord_fire_o = 1'b1;
      end else begin
        irq_grant_o = !mode_i && pend_i;
      end
      valid_o = ord_fire_o || irq_grant_o;
      if (irq_grant_o)     tid_o = IRQ_TID;
      else if (ord_fire_o) tid_o = TW'(owner_i);
    end
  end

endmodule

// File: rtl/tslot_sched.sv
module tslot_sched #(
  parameter int NUM_THREADS = 8,
  localparam int IW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int TW = $clog2(NUM_THREADS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] thread_ready,
  input  logic                   irq_req,
  input  logic                   policy_reserved,
  output logic                   issue_valid,
  output logic [TW-1:0]          issue_tid,
  output logic                   irq_ack
);

  logic [IW-1:0] owner;
  logic          res_slot;
  logic          mode_res;
  logic          rot_end;
  logic          pend;
  logic          irq_grant;
  logic          ord_fire;

  tslot_sequencer #(.NUM_THREADS(NUM_THREADS)) u_seq (
    .clk(clk), .rst(rst), .policy_i(policy_reserved),
    .owner_o(owner), .res_slot_o(res_slot), .mode_o(mode_res), .last_o(rot_end)
  );

  tslot_irq_tracker u_irq (
    .clk(clk), .rst(rst), .req_i(irq_req), .grant_i(irq_grant), .pend_o(pend)
  );

  tslot_issue_select #(.NUM_THREADS(NUM_THREADS)) u_sel (
    .rst(rst), .ready_i(thread_ready), .owner_i(owner), .res_slot_i(res_slot),
    .mode_i(mode_res), .pend_i(pend), .valid_o(issue_valid), .tid_o(issue_tid),
    .irq_grant_o(irq_grant), .ord_fire_o(ord_fire)
  );

  assign irq_ack = irq_grant;

  // An ordinary issue names a ready thread (R3)
  assert_ord_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && int'(issue_tid) < NUM_THREADS) |-> thread_ready[issue_tid]);

  // Acknowledge coincides with an issue of the interrupt thread (R2)
  assert_ack_tid_R2: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (issue_valid && int'(issue_tid) == NUM_THREADS));

  // Ordinary threads get at most every other slot in reserved mode (R4)
  assert_half_bw_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_res && ord_fire) |=> !ord_fire);

  // Two pending clocks in reserved mode always include the service (R5)
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_res && $past(mode_res) && pend && $past(pend)) |-> irq_ack);

endmodule

// File: tb/sim_tslot_sched.sv
`timescale 1ns/1ps
module sim_tslot_sched;
  localparam int N  = 8;
  localparam int TW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] rdy;
  logic req, pol;
  logic v, ack;
  logic [TW-1:0] tid;

  tslot_sched #(.NUM_THREADS(N)) u0 (
    .clk(clk), .rst(rst), .thread_ready(rdy), .irq_req(req),
    .policy_reserved(pol), .issue_valid(v), .issue_tid(tid), .irq_ack(ack)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the slot schedule
  int m_rr, m_cyc;
  bit m_res, m_mode, m_pend, m_armed;
  bit e_v, e_a;
  int e_t;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void expect_slot();
    e_v = 0; e_t = 0; e_a = 0;
    if (m_mode && m_res) begin
      if (m_pend) begin e_v = 1; e_t = N; e_a = 1; end
    end else if (rdy[m_rr]) begin
      e_v = 1; e_t = m_rr;
    end else if (!m_mode && m_pend) begin
      e_v = 1; e_t = N; e_a = 1;
    end
  endfunction

  function automatic void advance();
    bit cap;
    cap = req && m_armed && !m_pend;
    if (e_a) m_pend = 0; else if (cap) m_pend = 1;
    if (!req) m_armed = 1; else if (cap) m_armed = 0;
    if (m_rr == N-1 && (!m_mode || m_res)) begin
      m_rr = 0; m_res = 0; m_mode = pol;
    end else if (m_mode && !m_res) m_res = 1;
    else begin m_rr++; m_res = 0; end
    m_cyc++;
  endfunction

  // call at negedge with inputs set; checks, then moves one clock
  task automatic step();
    string tg;
    #0.5;
    expect_slot();
    tg = e_a ? (m_mode ? "R5" : "R3") : (m_mode ? "R4" : "R1");
    chk(v == e_v, tg, v, e_v);
    chk(int'(tid) == e_t, e_a ? "R2" : tg, tid, e_t);
    chk(ack == e_a, "R7", ack, e_a);
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst = 1; pol = p; req = 0; rdy = '1;
    @(posedge clk); @(negedge clk);
    chk(v == 0 && ack == 0, "R9", v, 0);
    @(posedge clk);
    m_rr = 0; m_res = 0; m_mode = p; m_pend = 0; m_armed = 1; m_cyc = 0;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240522));
    rst = 1; rdy = '1; req = 0; pol = 0;

    // R9: first slot after reset is thread 0
    do_reset(0);
    #0.5 chk(v == 1 && int'(tid) == 0, "R9", tid, 0);
    for (int k = 0; k < N; k++) step();

    // R1: all ready, full rotation in order
    for (int k = 0; k < N; k++) begin
      #0.5 chk(int'(tid) == k, "R1", tid, k);
      step();
    end

    // R6: thread 5 always ready, others random
    for (int k = 0; k < 6*N; k++) begin
      rdy = N'($urandom) | N'(1 << 5);
      #0.5;
      if (m_cyc % N == 5) chk(v && int'(tid) == 5, "R6", tid, 5);
      else chk(!(v && int'(tid) == 5), "R6", tid, -1);
      step();
    end

    // R3: interrupt waits for a slot whose owner is idle
    rdy = '1; rdy[3] = 0; req = 1;
    for (int k = 0; k < 2*N; k++) step();
    req = 0; step();

    // R8: policy change mid-rotation
    do_reset(0);
    step(); step();
    pol = 1;
    for (int k = 2; k < N; k++) begin
      #0.5 chk(v && int'(tid) == k, "R8", tid, k);
      step();
    end
    #0.5 chk(v && int'(tid) == 0, "R8", tid, 0);
    step();
    #0.5 chk(v == 0, "R8", v, 0);
    step();

    // R5: latency from either phase
    for (int ph = 0; ph < 2; ph++) begin
      int lat;
      do_reset(1);
      for (int k = 0; k < 4 + ph; k++) step();
      req = 1; step();
      lat = 1;
      while (!ack && lat < 6) begin #0.5; if (!ack) begin step(); lat++; end end
      chk(lat >= 1 && lat <= 2, "R5", lat, 1 + ph);
      // R7: held request gives no second acknowledge
      step();
      for (int k = 0; k < 2*N; k++) begin
        #0.5 chk(ack == 0, "R7", ack, 0);
        step();
      end
      req = 0; step(); step();
    end

    // mixed random run, policy flips
    do_reset(0);
    for (int k = 0; k < 1200; k++) begin
      rdy = N'($urandom);
      if ($urandom % 5 == 0) req = ~req;
      if ($urandom % 37 == 0) pol = ~pol;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule